// File: doc/BRIEF.md
# Programmable SPI Command Shift Engine

This block runs one single-line SPI transaction at a time for a serial flash device. Software fills up to six transmit byte registers and a bit-length register over a simple register bus, then sets a trigger bit. The engine pulls chip select low and shifts the requested number of bits out on MOSI, most significant bit first. It clocks MISO in on every rising SCK edge. When the transfer ends it releases chip select and clears the trigger bit, so software polls that bit to find out when the transfer is done.

Transmit data is taken starting with the highest-numbered transmit register and working down toward register 0. Once the loaded bytes are used up the engine keeps clocking and sends zeros, which lets the same transfer carry receive-only bytes. Every received bit shifts into a ten-byte capture bank. Capture index 0 always holds the newest byte and older bytes move up to higher indices. The serial clock runs in mode 0 and is derived from the system clock by a fixed half-period divider.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low and MOSI is low. Every register, including the trigger bit, reads back 0.
- R2: The length register (word address 1) holds the transfer length in bits. A written value above 56 is stored as 56. A trigger written while the length is 0 starts nothing.
- R3: Writing the control register (word address 0) with bit 2 set starts a transfer. Bit 2 reads 1 while the transfer runs and 0 once it has ended. A control write with bit 2 clear starts nothing, whatever its other bits hold.
- R4: MOSI carries transmit byte 5 first, then bytes 4, 3, 2, 1 and 0, each one MSB first. Transmit byte i sits at word address 2+i. Every bit after the 48th is sent as 0.
- R5: SCK idles low and runs only while chip select is low. Each SCK level lasts HALF_CYC system clocks. Chip select falls HALF_CYC clocks before the first rising edge and rises together with the last falling edge. MOSI changes only at chip-select fall or at a falling SCK edge.
- R6: MISO is sampled on each rising SCK edge and shifted into the capture bank at word addresses 8 to 17, one bit at a time. Capture index 0 holds the newest byte in its low bits and older bits move up. The bank is not cleared between transfers, and a final partial byte is right-aligned in index 0.
- R7: While a transfer runs, writes to the control, length and transmit registers are ignored. A second trigger neither restarts nor extends the transfer in progress.
- R8: The capture registers are read-only. A bus write to them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions take for granted that the bus presents at most one write per cycle and that reg_addr stays on one register for at least two cycles when software reads during a transfer. The stable-readback property of R7 depends on both of these. MISO is assumed to change only while SCK is low, as a mode-0 device behaves. The stimulus drives the bus and MISO only at falling system-clock edges, and it updates MISO only from a slave model that follows the expected SCK phase. Writes made during a transfer are placed well inside the frame, so they never coincide with the trigger edge itself.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_LEN    = 1;
  localparam int unsigned A_TX0    = 2;
  localparam int unsigned TRIG_BIT = 2;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } sck_phase_e;
endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_TOP);

  always_comb begin
    if (!run || (cnt_q == CNT_TOP)) cnt_d = '0;
    else                            cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter int unsigned TX_BYTES  = 6,
  parameter int unsigned CAP_BYTES = 10,
  parameter int unsigned LEN_W     = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        tick,
  input  logic [TX_BYTES*BYTE_W-1:0]  tx_flat,
  input  logic [LEN_W-1:0]            len,
  input  logic                        miso,
  output logic                        busy,
  output logic                        sck,
  output logic                        cs_n,
  output logic                        mosi,
  output logic [CAP_BYTES*BYTE_W-1:0] cap_flat
);
  localparam int unsigned TX_W  = TX_BYTES * BYTE_W;
  localparam int unsigned CAP_W = CAP_BYTES * BYTE_W;

  logic               busy_q, busy_d;
  sck_phase_e         ph_q, ph_d;
  logic [TX_W-1:0]    tx_q, tx_d;
  logic [LEN_W-1:0]   bit_q, bit_d;
  logic [CAP_W-1:0]   cap_q, cap_d;
  logic               step, last, adv;

  assign step = busy_q && tick;
  assign last = (bit_q == (len - LEN_W'(1)));
  assign adv  = start || step;

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    tx_d   = tx_q;
    bit_d  = bit_q;
    cap_d  = cap_q;
    if (start) begin
      busy_d = 1'b1;
      ph_d   = PH_LOW;
      tx_d   = tx_flat;
      bit_d  = '0;
    end else if (step) begin
      if (ph_q == PH_LOW) begin
        ph_d  = PH_HIGH;
        cap_d = {cap_q[CAP_W-2:0], miso};
      end else begin
        ph_d = PH_LOW;
        if (last) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + LEN_W'(1);
          tx_d  = {tx_q[TX_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_LOW;
      tx_q   <= '0;
      bit_q  <= '0;
      cap_q  <= '0;
    end else if (adv) begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      tx_q   <= tx_d;
      bit_q  <= bit_d;
      cap_q  <= cap_d;
    end
  end

  assign busy     = busy_q;
  assign sck      = (ph_q == PH_HIGH);
  assign cs_n     = !busy_q;
  assign mosi     = busy_q && tx_q[TX_W-1];
  assign cap_flat = cap_q;
endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int unsigned TX_BYTES  = 6,
  parameter int unsigned CAP_BYTES = 10,
  parameter int unsigned MAX_BITS  = 56,
  parameter int unsigned LEN_W     = 6,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  input  logic                        busy,
  input  logic [CAP_BYTES*BYTE_W-1:0] cap_flat,
  output logic [TX_BYTES*BYTE_W-1:0]  tx_flat,
  output logic [LEN_W-1:0]            len,
  output logic                        start
);
  localparam int unsigned CAP_BASE = A_TX0 + TX_BYTES;

  logic                wr_ok, len_we;
  logic [LEN_W-1:0]    len_q, len_d;
  logic [BYTE_W-1:0]   tx_q [TX_BYTES];
  logic [TX_BYTES-1:0] tx_we;

  assign wr_ok  = we && !busy;
  assign len_we = wr_ok && (addr == ADDR_W'(A_LEN));
  assign start  = wr_ok && (addr == ADDR_W'(A_CTRL)) && wdata[TRIG_BIT] && (len_q != '0);
  assign len_d  = (wdata > 32'(MAX_BITS)) ? LEN_W'(MAX_BITS) : wdata[LEN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_we) len_q <= len_d;
  end

  for (genvar gi = 0; gi < TX_BYTES; gi++) begin : g_tx
    assign tx_we[gi] = wr_ok && (addr == ADDR_W'(A_TX0 + gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tx_q[gi] <= '0;
      else if (tx_we[gi])  tx_q[gi] <= wdata[BYTE_W-1:0];
    end
    assign tx_flat[gi*BYTE_W +: BYTE_W] = tx_q[gi];
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL)) rdata[TRIG_BIT] = busy;
    if (addr == ADDR_W'(A_LEN))  rdata[LEN_W-1:0] = len_q;
    for (int i = 0; i < TX_BYTES; i++)
      if (addr == ADDR_W'(A_TX0 + i)) rdata[BYTE_W-1:0] = tx_q[i];
    for (int j = 0; j < CAP_BYTES; j++)
      if (addr == ADDR_W'(CAP_BASE + j)) rdata[BYTE_W-1:0] = cap_flat[j*BYTE_W +: BYTE_W];
  end

  assign len = len_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned HALF_CYC  = 2,
  parameter int unsigned TX_BYTES  = 6,
  parameter int unsigned CAP_BYTES = 10,
  parameter int unsigned MAX_BITS  = 56,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int unsigned LEN_W = $clog2(MAX_BITS + 1);

  logic [1:0]                   rsync_q;
  logic                         core_rst_n;
  logic                         busy, tick, start;
  logic [LEN_W-1:0]             len;
  logic [TX_BYTES*BYTE_W-1:0]   tx_flat;
  logic [CAP_BYTES*BYTE_W-1:0]  cap_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  spi_eng_regs #(
    .TX_BYTES(TX_BYTES), .CAP_BYTES(CAP_BYTES), .MAX_BITS(MAX_BITS),
    .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(core_rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .cap_flat(cap_flat),
    .tx_flat(tx_flat), .len(len), .start(start)
  );

  spi_eng_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(core_rst_n), .run(busy), .tick(tick)
  );

  spi_eng_seq #(
    .TX_BYTES(TX_BYTES), .CAP_BYTES(CAP_BYTES), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(core_rst_n), .start(start), .tick(tick),
    .tx_flat(tx_flat), .len(len), .miso(spi_miso), .busy(busy),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .cap_flat(cap_flat)
  );
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned MAX_BITS = 56
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              trig_bit,
  input logic [31:0]       reg_rdata,
  input logic              spi_sck,
  input logic              spi_cs_n,
  input logic              spi_mosi
);
  // R5: clock stays low outside a frame
  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R5: any SCK transition happens inside a frame
  a_r5_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sck) |-> !$past(spi_cs_n));

  // R5: data is already settled when the rising edge arrives
  a_r5_mosi_steady_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));

  // R3: a frame opens only after a control write with the trigger bit set
  a_r3_frame_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(reg_we && (reg_addr == ADDR_W'(0)) && trig_bit));

  // R2: the length readback never exceeds the maximum
  a_r2_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1)) |-> (reg_rdata <= 32'(MAX_BITS)));

  // R7: the length register cannot change mid-frame
  a_r7_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !$past(spi_cs_n) && (reg_addr == ADDR_W'(1)) && ($past(reg_addr) == ADDR_W'(1)))
      |-> $stable(reg_rdata));
endmodule

bind spi_cmd_engine spi_eng_chk #(.ADDR_W(ADDR_W), .MAX_BITS(MAX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .trig_bit(reg_wdata[2]), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
  .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam int H = 2;
  localparam int WATCHDOG = 150000;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int vecs = 0;
  int errs = 0;
  int cycles = 0;
  logic [79:0] cap_m;

  spi_cmd_engine #(.HALF_CYC(H)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errs = errs + 1;
      $display("FAIL R3 watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 5'd0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 5'(a);
    #1 d = reg_rdata;
  endtask

  task automatic idle_check(input string tag, input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      #1 chk(tag, {31'd0, spi_cs_n}, 32'd1);
    end
  endtask

  // Behavioural reference: expected pin levels for every cycle of a frame
  task automatic run_frame(input int len, input logic [47:0] txc,
                           input logic [63:0] pat, input bit busy_wr);
    logic [31:0] d;
    for (int i = 0; i < 6; i++) wr(2 + i, {24'd0, txc[i*8 +: 8]});
    wr(1, 32'(len));
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h4;
    for (int e = 0; e <= 2*H*len; e++) begin
      int p, k;
      bit infr;
      logic exp_mosi;
      @(negedge clk);
      p = e / H;
      k = p / 2;
      infr = (p < 2*len);
      reg_we = 1'b0; reg_addr = 5'd0; reg_wdata = '0;
      if (busy_wr && e == 1) begin reg_we = 1'b1; reg_addr = 5'd7; reg_wdata = 32'h3C ^ {24'd0, txc[47:40]}; end
      if (busy_wr && e == 2) begin reg_we = 1'b1; reg_addr = 5'd1; reg_wdata = 32'd3; end
      if (busy_wr && e == 3) begin reg_we = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h4; end
      spi_miso = infr ? pat[63-k] : 1'b0;
      exp_mosi = (infr && k < 48) ? txc[47-k] : 1'b0;
      #1;
      chk("R5 cs_n", {31'd0, spi_cs_n}, {31'd0, !infr});
      chk("R5 sck", {31'd0, spi_sck}, {31'd0, infr && (p % 2 == 1)});
      chk("R4 mosi", {31'd0, spi_mosi}, {31'd0, exp_mosi});
      if (reg_addr == 5'd0) chk("R3 busy bit", reg_rdata, infr ? 32'h4 : 32'h0);
    end
    reg_we = 1'b0;
    spi_miso = 1'b0;
    for (int b = 0; b < len; b++) cap_m = {cap_m[78:0], pat[63-b]};
    if (busy_wr) begin
      rd(7, d); chk("R7 tx5 kept", d, {24'd0, txc[47:40]});
      rd(1, d); chk("R7 len kept", d, 32'(len));
      idle_check("R7 retrigger ignored", 2*H + 2);
    end
    for (int j = 0; j < 10; j++) begin
      rd(8 + j, d);
      chk("R6 capture byte", d, {24'd0, cap_m[j*8 +: 8]});
    end
  endtask

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; spi_miso = 1'b0;
    cap_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
    chk("R1 sck", {31'd0, spi_sck}, 32'd0);
    chk("R1 mosi", {31'd0, spi_mosi}, 32'd0);
    for (int a = 0; a < 18; a++) begin
      rd(a, d); chk("R1 register", d, 32'd0);
    end

    wr(8, 32'hFF); wr(12, 32'h5A);
    rd(8, d);  chk("R8 capture write", d, 32'd0);
    rd(12, d); chk("R8 capture write", d, 32'd0);

    wr(1, 32'd200); rd(1, d); chk("R2 saturate", d, 32'd56);
    wr(1, 32'd57);  rd(1, d); chk("R2 saturate", d, 32'd56);
    wr(1, 32'd0);   wr(0, 32'h4);
    idle_check("R2 zero length", 6);
    rd(0, d); chk("R2 zero length busy", d, 32'd0);

    wr(1, 32'd8); wr(0, 32'h33);
    idle_check("R3 other bits", 6);
    rd(0, d); chk("R3 other bits busy", d, 32'd0);

    run_frame(16, 48'hA5_3C_00_00_00_00, 64'hC396_0000_0000_0000, 1'b0);
    run_frame(56, 48'h9F_01_23_45_67_89, 64'h5AA5_0FF0_1248_7E00, 1'b1);
    run_frame(11, 48'hFF_FF_00_00_AA_AA, 64'hE5A0_0000_0000_0000, 1'b0);
    run_frame(1,  48'h80_00_00_00_00_00, 64'h8000_0000_0000_0000, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule